// File: doc/BRIEF.md
# Guarded Predicate Register File

This block holds the single-bit condition flags of one thread in a small SIMT-style core. Each instruction carries a 4-bit guard. The block reads the flag that the guard names, applies an optional inversion, and raises an execute signal that tells the pipeline whether the instruction takes effect. Predicate-logic instructions read two flags through separate ports and write one result back through a single-flag write port.

There are seven writable flags. The eighth index is wired to a constant one. An unguarded instruction therefore uses the all-ones index with no inversion, and a never-executing guard uses the same index inverted.

When a compiler runs out of flags, it can spill them. A pack operation copies the whole flag set into a 32-bit general-register word. An unpack operation restores chosen flags from such a word under a per-flag mask.

Top module: `pred_guard_file`

## Requirements
- R1: An active-high synchronous reset clears flags 0..6 to 0, so the packed word reads 0 on the cycle after reset.
- R2: Guard bit 3 is an inversion flag and guard bits 2:0 are a flag index. The execute output equals the indexed flag XOR the inversion flag.
- R3: Index 3'b111 reads as 1 on both read ports and in the guard. Guard 4'b0111 always executes and guard 4'b1111 never executes.
- R4: A single-flag write to index 7 changes no flag.
- R5: A single-flag write becomes visible on the clock edge. A read of the same flag in the cycle of the write returns the old value.
- R6: The two read ports select flags independently and at the same time, each returning the value of the flag it indexes.
- R7: The packed word carries flag i in bit i for i = 0..6, and bits 31:7 are always 0.
- R8: When unpack is enabled, flag i (i = 0..6) loads word bit i where mask bit i is 1 and keeps its value where mask bit i is 0. Mask bit 7 and word bits 31:7 have no effect.
- R9: If a single-flag write and an unpack target the same flag in one cycle, the single-flag write sets that flag. Other masked flags still take their unpack values.
- R10: With neither write nor unpack enabled, all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| guard_i | input | 4 | Instruction guard: bit 3 inverts, bits 2:0 index |
| exec_o | output | 1 | Instruction executes when 1 |
| rd_a_idx_i | input | 3 | Read port A index |
| rd_a_val_o | output | 1 | Read port A value |
| rd_b_idx_i | input | 3 | Read port B index |
| rd_b_val_o | output | 1 | Read port B value |
| wr_en_i | input | 1 | Single-flag write enable |
| wr_idx_i | input | 3 | Single-flag write index |
| wr_val_i | input | 1 | Single-flag write value |
| unpack_en_i | input | 1 | Load flags from a register word |
| unpack_mask_i | input | 8 | Per-flag load mask (bit 7 unused) |
| unpack_data_i | input | 32 | Register word to load from |
| pack_data_o | output | 32 | All flags packed into a register word |

## Verification
The hardest case to reach is a single-flag write and an unpack that hit the same flag in one cycle. It matters most when the two disagree, and when they land in a cycle where other masked flags also change. The stimulus table drives both ports together, with opposite values on the shared flag and a second masked flag that moves the other way. The test then reads the outcome from the packed word. The same-cycle old-value read is reached by holding a read index on a flag while writing it, sampling once before the edge and once after.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
    localparam int IDX_W    = 3;
    localparam int ENTRIES  = 1 << IDX_W;
    localparam int NUM_PRED = ENTRIES - 1;
    localparam int GUARD_W  = IDX_W + 1;
    localparam int GPR_W    = 32;

    typedef logic [NUM_PRED-1:0] pred_vec_t;

    typedef struct packed {
        pred_vec_t flags;
    } pfile_state_t;
endpackage

// File: rtl/pgf_read_port.sv
module pgf_read_port #(
    parameter int IDX_W    = 3,
    parameter int NUM_PRED = 7
) (
    input  logic [NUM_PRED-1:0] flags_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic                val_o
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] ext;

    // Slots past the writable flags read as constant true.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        if (g < NUM_PRED) begin : g_real
            assign ext[g] = flags_i[g];
        end else begin : g_true
            assign ext[g] = 1'b1;
        end
    end

    assign val_o = ext[idx_i];
endmodule

// File: rtl/pgf_guard_eval.sv
module pgf_guard_eval #(
    parameter int IDX_W    = 3,
    parameter int NUM_PRED = 7
) (
    input  logic [NUM_PRED-1:0] flags_i,
    input  logic [IDX_W:0]      guard_i,
    output logic                exec_o
);
    logic sel_val;

    pgf_read_port #(.IDX_W(IDX_W), .NUM_PRED(NUM_PRED)) u_sel (
        .flags_i (flags_i),
        .idx_i   (guard_i[IDX_W-1:0]),
        .val_o   (sel_val)
    );

    // Top guard bit inverts the selected flag.
    assign exec_o = sel_val ^ guard_i[IDX_W];
endmodule

// File: rtl/pgf_pack.sv
module pgf_pack #(
    parameter int NUM_PRED = 7,
    parameter int GPR_W    = 32
) (
    input  logic [NUM_PRED-1:0] flags_i,
    output logic [GPR_W-1:0]    word_o
);
    localparam int PAD_W = GPR_W - NUM_PRED;

    assign word_o = {{PAD_W{1'b0}}, flags_i};
endmodule

// File: rtl/pred_guard_file.sv
module pred_guard_file
    import pgf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [GUARD_W-1:0] guard_i,
    output logic               exec_o,
    input  logic [IDX_W-1:0]   rd_a_idx_i,
    output logic               rd_a_val_o,
    input  logic [IDX_W-1:0]   rd_b_idx_i,
    output logic               rd_b_val_o,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic               wr_val_i,
    input  logic               unpack_en_i,
    input  logic [ENTRIES-1:0] unpack_mask_i,
    input  logic [GPR_W-1:0]   unpack_data_i,
    output logic [GPR_W-1:0]   pack_data_o
);
    pfile_state_t state_d, state_q;

    // Next-state: unpack first, then the single write overrides it.
    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_PRED; i++) begin
            if (unpack_en_i && unpack_mask_i[i]) begin
                state_d.flags[i] = unpack_data_i[i];
            end
            if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                state_d.flags[i] = wr_val_i;
            end
        end
        if (rst) begin
            state_d.flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    pgf_guard_eval #(.IDX_W(IDX_W), .NUM_PRED(NUM_PRED)) u_guard (
        .flags_i (state_q.flags),
        .guard_i (guard_i),
        .exec_o  (exec_o)
    );

    pgf_read_port #(.IDX_W(IDX_W), .NUM_PRED(NUM_PRED)) u_rd_a (
        .flags_i (state_q.flags),
        .idx_i   (rd_a_idx_i),
        .val_o   (rd_a_val_o)
    );

    pgf_read_port #(.IDX_W(IDX_W), .NUM_PRED(NUM_PRED)) u_rd_b (
        .flags_i (state_q.flags),
        .idx_i   (rd_b_idx_i),
        .val_o   (rd_b_val_o)
    );

    pgf_pack #(.NUM_PRED(NUM_PRED), .GPR_W(GPR_W)) u_pack (
        .flags_i (state_q.flags),
        .word_o  (pack_data_o)
    );

    localparam logic [IDX_W-1:0] TRUE_IDX = '1;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pack_data_o == '0));

    assert_true_guard_R3: assert property (@(posedge clk) disable iff (rst)
        (guard_i == {1'b0, TRUE_IDX}) |-> exec_o);

    assert_true_guard_inverted_R3: assert property (@(posedge clk) disable iff (rst)
        (guard_i == {1'b1, TRUE_IDX}) |-> !exec_o);

    assert_true_read_a_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx_i == TRUE_IDX) |-> rd_a_val_o);

    assert_true_read_b_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx_i == TRUE_IDX) |-> rd_b_val_o);

    assert_write_true_idx_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i == TRUE_IDX && !unpack_en_i) |=> $stable(pack_data_o));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i != TRUE_IDX) |=> (pack_data_o[$past(wr_idx_i)] == $past(wr_val_i)));

    assert_pack_high_zero_R7: assert property (@(posedge clk) disable iff (rst)
        pack_data_o[GPR_W-1:NUM_PRED] == '0);

    assert_unpack_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
        (unpack_en_i && unpack_mask_i == '1 && unpack_data_i == '0 && !wr_en_i)
        |=> (pack_data_o == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !unpack_en_i) |=> $stable(pack_data_o));
endmodule

// File: tb/tb_pred_guard_file.sv
module tb_pred_guard_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  guard_i = '0;
    logic        exec_o;
    logic [2:0]  rd_a_idx_i = '0;
    logic        rd_a_val_o;
    logic [2:0]  rd_b_idx_i = '0;
    logic        rd_b_val_o;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_idx_i = '0;
    logic        wr_val_i = 1'b0;
    logic        unpack_en_i = 1'b0;
    logic [7:0]  unpack_mask_i = '0;
    logic [31:0] unpack_data_i = '0;
    logic [31:0] pack_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pred_guard_file dut (
        .clk(clk), .rst(rst), .guard_i(guard_i), .exec_o(exec_o),
        .rd_a_idx_i(rd_a_idx_i), .rd_a_val_o(rd_a_val_o),
        .rd_b_idx_i(rd_b_idx_i), .rd_b_val_o(rd_b_val_o),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_val_i(wr_val_i),
        .unpack_en_i(unpack_en_i), .unpack_mask_i(unpack_mask_i),
        .unpack_data_i(unpack_data_i), .pack_data_o(pack_data_o)
    );

    // {wr_en, wr_idx[2:0], wr_val, un_en, mask[7:0], data[7:0], expected_pack[7:0]}
    localparam int NVEC = 9;
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b1, 3'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h04},  // R5 write P2
        {1'b1, 3'd6, 1'b1, 1'b0, 8'h00, 8'h00, 8'h44},  // R5 write P6
        {1'b1, 3'd7, 1'b1, 1'b0, 8'h00, 8'h00, 8'h44},  // R4 index 7 ignored
        {1'b0, 3'd0, 1'b0, 1'b1, 8'h0F, 8'h0B, 8'h4B},  // R8 masked unpack
        {1'b0, 3'd0, 1'b0, 1'b1, 8'h80, 8'hFF, 8'h4B},  // R8 mask bit 7 ignored
        {1'b1, 3'd0, 1'b0, 1'b1, 8'h01, 8'h01, 8'h4A},  // R9 write beats unpack
        {1'b1, 3'd5, 1'b1, 1'b1, 8'h60, 8'h00, 8'h2A},  // R9 mixed
        {1'b0, 3'd0, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h2A},  // R10 hold
        {1'b0, 3'd0, 1'b0, 1'b1, 8'h7F, 8'h55, 8'h55}   // R8 full unpack
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en_i = 1'b0; unpack_en_i = 1'b0; unpack_mask_i = '0;
        unpack_data_i = '0; wr_idx_i = '0; wr_val_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] model;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1", pack_data_o, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en_i       = VEC[v][29];
            wr_idx_i      = VEC[v][28:26];
            wr_val_i      = VEC[v][25];
            unpack_en_i   = VEC[v][24];
            unpack_mask_i = VEC[v][23:16];
            unpack_data_i = {24'hA5A5A5, VEC[v][15:8]};
            @(negedge clk);
            idle_inputs();
            check("R4/R5/R8/R9/R10 vector", pack_data_o, {24'h0, VEC[v][7:0]});
            check("R7 high bits", {7'h0, pack_data_o[31:7]}, 32'h0);
        end

        // State is now 0x55: P0,P2,P4,P6 = 1.
        model = 8'hD5;  // bit 7 is the constant-true slot
        for (int g = 0; g < 16; g++) begin
            guard_i = 4'(g);
            #1;
            check("R2/R3 guard", {31'h0, exec_o}, {31'h0, model[g[2:0]] ^ g[3]});
        end
        for (int i = 0; i < 8; i++) begin
            rd_a_idx_i = 3'(i);
            rd_b_idx_i = 3'(7 - i);
            #1;
            check("R6/R3 port A", {31'h0, rd_a_val_o}, {31'h0, model[i]});
            check("R6/R3 port B", {31'h0, rd_b_val_o}, {31'h0, model[7 - i]});
        end

        // R5: same-cycle read of the written flag returns the old value.
        @(negedge clk);
        rd_a_idx_i = 3'd1;
        wr_en_i = 1'b1; wr_idx_i = 3'd1; wr_val_i = 1'b1;
        #1;
        check("R5 old value", {31'h0, rd_a_val_o}, 32'h0);
        @(negedge clk);
        idle_inputs();
        check("R5 new value", {31'h0, rd_a_val_o}, 32'h1);
        check("R7 pack layout", pack_data_o, 32'h57);

        // R1: reset in mid-run.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", pack_data_o, 32'h0);
        guard_i = 4'b0000;
        #1;
        check("R2 cleared guard", {31'h0, exec_o}, 32'h0);
        guard_i = 4'b1000;
        #1;
        check("R2 cleared inverted", {31'h0, exec_o}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule